// File: doc/BRIEF.md
# Row-Activated Popcount Dot-Product Engine

This block computes a column sum for weights that are one bit wide. The weights sit in a small square bit array that lives outside the block. When a start request is accepted, the engine steps through the array one row per clock. A row counts only if its bit is set in an activation vector. For each such row, the engine adds the number of ones in that row to a 16-bit accumulator. The result is the dot product of the activation vector with the per-row weight totals.

The array is shared with a self-test engine. A start request made while the self-test is busy is held back and launches once the self-test goes idle. The engine's own running output lets the self-test side hold off in the same way. The host sees four things: a running flag, a sticky done flag that it clears by a write-one-to-clear pulse, a zero-result flag, and the accumulator. The accumulator stays fixed between runs, so both of its bytes can be read at leisure.

Top module: `cim_dot_engine`

## Requirements
- R1: After reset, running_o, done_o and acc_zero_o are 0, acc_o is 0 and row_idx_o is 0.
- R2: A start that is accepted raises running_o at the next clock edge. The run lasts exactly ROWS cycles. At the edge that ends it, running_o falls and done_o is set.
- R3: At the end of a run, acc_o equals the sum, over every row r whose bit r of the activation vector is 1, of the number of ones in row_data_i while row_idx_o = r. Rows whose bit is 0 add nothing.
- R4: Accepting a start clears the accumulator, so acc_o reads 0 in the first running cycle.
- R5: The activation vector is captured at the edge that accepts the start. Changes to act_vec_i during the run have no effect on the result.
- R6: While bist_busy_i is 1, no run starts. A start request seen during that time is remembered and launches at the first edge at which bist_busy_i is 0.
- R7: A start request made while a run is in progress is ignored. It neither restarts the run nor launches a second run afterwards.
- R8: done_o stays set until a done_clr_i pulse arrives, which clears it at the next edge. If the clear and a run's completion fall on the same edge, done_o ends up set.
- R9: acc_zero_o is 1 exactly when done_o is 1, no run is in progress, and acc_o is 0.
- R10: acc_o does not change while no run is in progress, whatever row_data_i does.
- R11: During a run, row_idx_o starts at 0 and goes up by one every cycle, ending at ROWS-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request, one cycle |
| done_clr_i | input | 1 | Write-one-to-clear pulse for done_o |
| bist_busy_i | input | 1 | Self-test engine is running |
| act_vec_i | input | ROWS (8) | Activation vector, bit r selects row r |
| row_idx_o | output | clog2(ROWS) (3) | Row address to the shared array |
| row_data_i | input | COLS (8) | Cells of the addressed row, combinational read |
| running_o | output | 1 | Run in progress |
| done_o | output | 1 | Sticky completion flag |
| acc_zero_o | output | 1 | Completed result is zero |
| acc_o | output | ACC_W (16) | Accumulator |

## Verification
The bench goes after the corners where timing and results are easy to get wrong:
- A request held off by the self-test must launch exactly once, one edge after bist_busy_i drops. A design that drops the request would never raise running_o; one that ignores the lock would start too early.
- A second start made in the middle of a run must change neither its length nor its sum. Re-arming would show a second run; restarting would show a late finish.
- A done clear that lands on the completion edge must leave done_o set.
- The activation vector must be the one captured at start. A late change to act_vec_i would show a wrong sum.
- The zero flag must drop while a later run is in progress, and the accumulator must hold after done while the array data moves underneath it.

// File: rtl/cim_dot_pkg.sv
package cim_dot_pkg;
  typedef enum logic {
    WLK_IDLE = 1'b0,
    WLK_RUN  = 1'b1
  } walk_state_e;
endpackage

// File: rtl/cim_popcount.sv
module cim_popcount #(
  parameter int W    = 8,
  parameter int PC_W = $clog2(W + 1)
) (
  input  logic [W-1:0]    bits_i,
  output logic [PC_W-1:0] cnt_o
);
  always_comb begin
    cnt_o = '0;
    for (int i = 0; i < W; i++) cnt_o = cnt_o + PC_W'(bits_i[i]);
  end
endmodule

// File: rtl/cim_row_walker.sv
module cim_row_walker
  import cim_dot_pkg::*;
#(
  parameter int ROWS = 8,
  parameter int CW   = $clog2(ROWS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          bist_busy_i,
  input  logic          done_clr_i,
  output logic          go_o,
  output logic          running_o,
  output logic [CW-1:0] row_o,
  output logic          done_o
);
  localparam logic [CW-1:0] LAST_ROW = CW'(ROWS - 1);

  walk_state_e state_q;
  logic [CW-1:0] row_q;
  logic pend_q, done_q, last;

  assign running_o = (state_q == WLK_RUN);
  assign last      = running_o && (row_q == LAST_ROW);
  // request from port or held-off queue; self-test has priority
  assign go_o      = (start_i || pend_q) && !running_o && !bist_busy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= WLK_IDLE;
      row_q   <= '0;
      pend_q  <= 1'b0;
    end else begin
      if (go_o) pend_q <= 1'b0;
      else if (start_i && !running_o && bist_busy_i) pend_q <= 1'b1;

      if (go_o) begin
        state_q <= WLK_RUN;
        row_q   <= '0;
      end else if (last) begin
        state_q <= WLK_IDLE;
        row_q   <= '0;
      end else if (running_o) begin
        row_q <= row_q + 1'b1;
      end
    end
  end

  // completion wins over a coincident clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         done_q <= 1'b0;
    else if (last)       done_q <= 1'b1;
    else if (done_clr_i) done_q <= 1'b0;
  end

  assign row_o  = row_q;
  assign done_o = done_q;
endmodule

// File: rtl/cim_accum.sv
module cim_accum #(
  parameter int ROWS  = 8,
  parameter int PC_W  = 4,
  parameter int ACC_W = 16,
  parameter int CW    = $clog2(ROWS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             go_i,
  input  logic             running_i,
  input  logic [CW-1:0]    row_i,
  input  logic [ROWS-1:0]  act_vec_i,
  input  logic [PC_W-1:0]  pc_i,
  output logic [ACC_W-1:0] acc_o
);
  logic [ROWS-1:0]  act_q;
  logic [ACC_W-1:0] acc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= '0;
      acc_q <= '0;
    end else if (go_i) begin
      act_q <= act_vec_i;
      acc_q <= '0;
    end else if (running_i && act_q[row_i]) begin
      acc_q <= acc_q + {{(ACC_W-PC_W){1'b0}}, pc_i};
    end
  end

  assign acc_o = acc_q;
endmodule

// File: rtl/cim_dot_engine.sv
module cim_dot_engine #(
  parameter int ROWS  = 8,
  parameter int COLS  = 8,
  parameter int ACC_W = 16,
  localparam int CW   = $clog2(ROWS),
  localparam int PC_W = $clog2(COLS + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             done_clr_i,
  input  logic             bist_busy_i,
  input  logic [ROWS-1:0]  act_vec_i,
  output logic [CW-1:0]    row_idx_o,
  input  logic [COLS-1:0]  row_data_i,
  output logic             running_o,
  output logic             done_o,
  output logic             acc_zero_o,
  output logic [ACC_W-1:0] acc_o
);
  logic go;
  logic [PC_W-1:0] pc;

  cim_row_walker #(.ROWS(ROWS)) walk_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .bist_busy_i(bist_busy_i),
    .done_clr_i (done_clr_i),
    .go_o       (go),
    .running_o  (running_o),
    .row_o      (row_idx_o),
    .done_o     (done_o)
  );

  cim_popcount #(.W(COLS), .PC_W(PC_W)) pc_i (
    .bits_i(row_data_i),
    .cnt_o (pc)
  );

  cim_accum #(.ROWS(ROWS), .PC_W(PC_W), .ACC_W(ACC_W)) acc_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .go_i     (go),
    .running_i(running_o),
    .row_i    (row_idx_o),
    .act_vec_i(act_vec_i),
    .pc_i     (pc),
    .acc_o    (acc_o)
  );

  assign acc_zero_o = done_o && !running_o && (acc_o == '0);
endmodule

// File: rtl/cim_dot_engine_chk.sv
module cim_dot_engine_chk #(
  parameter int ROWS  = 8,
  parameter int ACC_W = 16,
  parameter int CW    = $clog2(ROWS)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             done_clr_i,
  input logic             bist_busy_i,
  input logic [CW-1:0]    row_idx_o,
  input logic             running_o,
  input logic             done_o,
  input logic [ACC_W-1:0] acc_o
);
  localparam logic [CW-1:0] LAST_ROW = CW'(ROWS - 1);

  // R2
  run_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    running_o && row_idx_o == LAST_ROW |=> !running_o && done_o);

  // R11
  row_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    running_o && row_idx_o != LAST_ROW |=> running_o && row_idx_o == CW'($past(row_idx_o) + 1'b1));

  // R6
  bist_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bist_busy_i && !running_o |=> !running_o);

  // R4
  acc_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(running_o) |-> acc_o == '0);

  // R10
  acc_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !running_o |=> running_o || $stable(acc_o));

  // R8
  done_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !done_clr_i |=> done_o);
endmodule

bind cim_dot_engine cim_dot_engine_chk #(.ROWS(ROWS), .ACC_W(ACC_W)) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .done_clr_i (done_clr_i),
  .bist_busy_i(bist_busy_i),
  .row_idx_o  (row_idx_o),
  .running_o  (running_o),
  .done_o     (done_o),
  .acc_o      (acc_o)
);

// File: tb/cim_dot_engine_tb.sv
module cim_dot_engine_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, done_clr = 1'b0, bist_busy = 1'b0;
  logic [7:0]  act = '0;
  logic [2:0]  row_idx;
  logic [7:0]  row_data;
  logic        running, done, acc_zero;
  logic [15:0] acc;
  logic [7:0]  mem [8];
  int total = 0, bad = 0;

  always #5 clk = ~clk;
  assign row_data = mem[row_idx];

  cim_dot_engine dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .done_clr_i(done_clr),
    .bist_busy_i(bist_busy), .act_vec_i(act), .row_idx_o(row_idx),
    .row_data_i(row_data), .running_o(running), .done_o(done),
    .acc_zero_o(acc_zero), .acc_o(acc)
  );

  // {activation, array rows 7..0, expected sum}
  localparam logic [87:0] VEC [7] = '{
    {8'hFF, 64'hFFFFFFFFFFFFFFFF, 16'd64},
    {8'h00, 64'hFFFFFFFFFFFFFFFF, 16'd0},
    {8'hFF, 64'h0000000000000000, 16'd0},
    {8'hA5, 64'h0101010101010101, 16'd4},
    {8'hF0, 64'h7F3F1F0F07030100, 16'd22},
    {8'h0F, 64'h7F3F1F0F07030100, 16'd6},
    {8'h81, 64'hAA55AA55AA55AA55, 16'd8}
  };

  task automatic check(input bit ok, input string req, input int actv, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, actv, expv);
    end
  endtask

  task automatic load(input logic [63:0] m);
    for (int r = 0; r < 8; r++) mem[r] = m[8*r +: 8];
  endtask

  // start at a negedge; returns at the negedge after the last row edge
  task automatic run(input logic [7:0] a, input int expv, input bit clr_at_end);
    act = a; start = 1'b1;
    @(negedge clk); start = 1'b0;
    check(running == 1'b1, "R2 running after accept", running, 1);
    check(acc == 16'd0, "R4 acc cleared", acc, 0);
    check(acc_zero == 1'b0, "R9 zero flag low in run", acc_zero, 0);
    for (int i = 0; i < 8; i++) begin
      check(running == 1'b1 && row_idx == 3'(i), "R11 row walk", row_idx, i);
      if (i == 7 && clr_at_end) done_clr = 1'b1;
      @(negedge clk);
      done_clr = 1'b0;
    end
    check(running == 1'b0, "R2 run ends", running, 0);
    check(done == 1'b1, "R2 done set", done, 1);
    check(acc == 16'(expv), "R3 sum", acc, expv);
    check(acc_zero == (expv == 0), "R9 zero flag", acc_zero, expv == 0);
  endtask

  initial begin
    #500000;
    bad++; total++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    load(64'h0);
    #12;
    check(running == 0 && done == 0 && acc_zero == 0, "R1 flags", {running, done, acc_zero}, 0);
    check(acc == 0 && row_idx == 0, "R1 acc/row", acc, 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);

    foreach (VEC[k]) begin
      load(VEC[k][79:16]);
      run(VEC[k][87:80], int'(VEC[k][15:0]), 1'b0);
    end

    // R8: clear works and is sticky otherwise
    repeat (2) @(negedge clk);
    check(done == 1'b1, "R8 sticky", done, 1);
    done_clr = 1'b1; @(negedge clk); done_clr = 1'b0;
    check(done == 1'b0, "R8 cleared", done, 0);

    // R8: completion beats coincident clear
    load(64'hFFFFFFFFFFFFFFFF);
    run(8'h03, 16, 1'b1);

    // R10: hold after done while array changes
    load(64'h0);
    repeat (3) @(negedge clk);
    check(acc == 16'd16, "R10 acc held", acc, 16);

    // R5: activation captured at start
    load(64'hFFFFFFFFFFFFFFFF);
    act = 8'hFF; start = 1'b1;
    @(negedge clk); start = 1'b0; act = 8'h00;
    repeat (8) @(negedge clk);
    check(acc == 16'd64, "R5 captured vector", acc, 64);

    // R9: zero result, then clear drops flag
    run(8'h00, 0, 1'b0);
    done_clr = 1'b1; @(negedge clk); done_clr = 1'b0;
    check(acc_zero == 1'b0, "R9 flag needs done", acc_zero, 0);

    // R6: held off by self-test, launches once released
    bist_busy = 1'b1; act = 8'h01; start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (4) begin
      check(running == 1'b0, "R6 held off", running, 0);
      @(negedge clk);
    end
    bist_busy = 1'b0;
    @(negedge clk);
    check(running == 1'b1, "R6 launch after release", running, 1);
    repeat (8) @(negedge clk);
    check(running == 1'b0 && acc == 16'd8, "R6 result", acc, 8);

    // R7: start mid-run ignored
    act = 8'hFF; start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (3) @(negedge clk);
    start = 1'b1; @(negedge clk); start = 1'b0;
    repeat (3) @(negedge clk);
    check(running == 1'b1, "R7 still in run", running, 1);
    @(negedge clk);
    check(running == 1'b0 && acc == 16'd64, "R7 original end", acc, 64);
    repeat (3) begin
      @(negedge clk);
      check(running == 1'b0, "R7 not re-armed", running, 0);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule